// File: doc/BRIEF.md
# Multi-Mode Mantissa Rounding Stage

This block is the rounding step of a floating-point datapath. A mantissa arrives with two extra low-order bits: the guard bit sits above the round bit. A separate sticky bit records whether anything nonzero was shifted out below them. A sign bit and a 2-bit mode selector complete the input. The stage removes the guard and round bits and decides whether to add one unit in the last place. It then performs that addition with a carry that runs across the whole mantissa.

The result is one bit wider than the value field. A carry out of the top bit, such as all ones rounding up to 2.0, therefore stays visible to the caller. Renormalising after that carry and packing the exponent are left to the downstream packer. The packer uses the exported round-up flag to detect a step into the next binade. The stage also reports whether the result was inexact.

The stage has one register. Every result is computed in a single combinational pass and registered. Outputs are valid one clock after the inputs are presented.

Top module: `mant_round`

## Requirements
- R1: While the active-low reset is asserted, `mant_o`, `incr_o`, `inexact_o` and `sticky_o` are all zero.
- R2: One clock after an input is sampled, `mant_o` equals the input mantissa shifted right by two, plus `incr_o`.
- R3: When guard (bit 1), round (bit 0) and sticky are all zero, the result is exact: `incr_o` and `inexact_o` are both 0.
- R4: `inexact_o` is 1 exactly when at least one of guard, round or sticky is 1, in every mode.
- R5: With mode 2'b00 (nearest), an increment happens only if guard is 1 and at least one of these holds: round is 1, sticky is 1, or bit 2 of the input (the LSB after the shift) is 1. An exact tie therefore rounds to even.
- R6: With mode 2'b01 (toward zero), no increment ever happens.
- R7: With mode 2'b10 (toward minus infinity), an increment happens exactly when the result is inexact and the sign is 1.
- R8: With mode 2'b11 (toward plus infinity), an increment happens exactly when the result is inexact and the sign is 0.
- R9: The increment carries through every value bit. A value field of all ones that is incremented gives `mant_o` with only its top bit set.
- R10: `sticky_o` is 0 after every rounding operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Sign of the value being rounded (1 = negative) |
| mant_i | input | MANT_W+2 | Mantissa; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of all bits already discarded below round |
| mode_i | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| mant_o | output | MANT_W+1 | Rounded mantissa, including the carry-out bit |
| incr_o | output | 1 | One unit in the last place was added |
| inexact_o | output | 1 | Guard, round or sticky was nonzero |
| sticky_o | output | 1 | Sticky after rounding (always cleared) |

## Verification
All three results (`mant_o`, `incr_o` and `inexact_o`) come out of the same register. Each is due exactly one rising edge after its inputs are applied. The bench drives a vector on a falling edge and reads the outputs on the next falling edge. It then applies the following vector, so each comparison sees only the vector that was just registered. The bound properties use the same one-cycle offset: each compares the outputs with the previous cycle's inputs, and only when the previous cycle was out of reset.

// File: rtl/mant_round_pkg.sv
package mant_round_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_TO_ZERO = 2'b01,
        RM_DOWN    = 2'b10,
        RM_UP      = 2'b11
    } rmode_e;

    typedef struct packed {
        logic incr;
        logic inexact;
    } rdec_t;

endpackage

// File: rtl/mant_round_decide.sv
module mant_round_decide
    import mant_round_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       sign_i,
    input  logic       guard_i,
    input  logic       rbit_i,
    input  logic       sticky_i,
    input  logic       lsb_i,
    output rdec_t      dec_o
);

    rmode_e mode;
    logic   lost;

    always_comb begin
        mode         = rmode_e'(mode_i);
        lost         = guard_i | rbit_i | sticky_i;
        dec_o        = '0;
        dec_o.inexact = lost;
        unique case (mode)
            RM_NEAREST: dec_o.incr = guard_i & (rbit_i | sticky_i | lsb_i);
            RM_TO_ZERO: dec_o.incr = 1'b0;
            RM_DOWN:    dec_o.incr = lost & sign_i;
            RM_UP:      dec_o.incr = lost & ~sign_i;
            default:    dec_o.incr = guard_i & (rbit_i | sticky_i | lsb_i);
        endcase
    end

endmodule

// File: rtl/mant_round_inc.sv
module mant_round_inc #(
    parameter int W = 64
) (
    input  logic [W-1:0] val_i,
    input  logic         inc_i,
    output logic [W:0]   sum_o
);

    localparam int SW = W + 1;

    always_comb begin
        sum_o = {1'b0, val_i} + SW'(inc_i);
    end

endmodule

// File: rtl/mant_round.sv
module mant_round
    import mant_round_pkg::*;
#(
    parameter int MANT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sign_i,
    input  logic [MANT_W+1:0] mant_i,
    input  logic              sticky_i,
    input  logic [1:0]        mode_i,
    output logic [MANT_W:0]   mant_o,
    output logic              incr_o,
    output logic              inexact_o,
    output logic              sticky_o
);

    localparam int OUT_W = MANT_W + 1;

    typedef struct packed {
        logic [OUT_W-1:0] mant;
        logic             incr;
        logic             inexact;
        logic             sticky;
    } rstate_t;

    rstate_t st_d, st_q;

    logic [MANT_W-1:0] trunc;
    logic [OUT_W-1:0]  sum;
    rdec_t             dec;

    assign trunc = mant_i[MANT_W+1:2];

    mant_round_decide u_decide (
        .mode_i   (mode_i),
        .sign_i   (sign_i),
        .guard_i  (mant_i[1]),
        .rbit_i   (mant_i[0]),
        .sticky_i (sticky_i),
        .lsb_i    (trunc[0]),
        .dec_o    (dec)
    );

    mant_round_inc #(.W(MANT_W)) u_inc (
        .val_i (trunc),
        .inc_i (dec.incr),
        .sum_o (sum)
    );

    always_comb begin
        st_d         = st_q;
        st_d.mant    = sum;
        st_d.incr    = dec.incr;
        st_d.inexact = dec.inexact;
        st_d.sticky  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mant_o    = st_q.mant;
    assign incr_o    = st_q.incr;
    assign inexact_o = st_q.inexact;
    assign sticky_o  = st_q.sticky;

endmodule

// File: rtl/mant_round_chk.sv
module mant_round_chk #(
    parameter int MANT_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sign_i,
    input logic [MANT_W+1:0] mant_i,
    input logic              sticky_i,
    input logic [1:0]        mode_i,
    input logic [MANT_W:0]   mant_o,
    input logic              incr_o,
    input logic              inexact_o
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2: the registered mantissa is the shifted input plus the reported increment
    p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (mant_o == (MANT_W+1)'($past(mant_i[MANT_W+1:2])) + (MANT_W+1)'(incr_o)));

    // R3
    p_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(mant_i[1:0] == 2'b00 && !sticky_i)) |-> (!incr_o && !inexact_o));

    // R4
    p_inexact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (inexact_o == $past(mant_i[1] | mant_i[0] | sticky_i)));

    // R5
    p_near_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(mode_i == 2'b00 && !mant_i[1])) |-> !incr_o);

    // R6
    p_rtz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(mode_i == 2'b01)) |-> !incr_o);

    // R7
    p_down_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(mode_i == 2'b10 && !sign_i)) |-> !incr_o);

    // R8
    p_up_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(mode_i == 2'b11 && sign_i)) |-> !incr_o);

endmodule

bind mant_round mant_round_chk #(.MANT_W(MANT_W)) u_chk (.*);

// File: tb/tb_mant_round.sv
module tb_mant_round;

    localparam int SW  = 6;
    localparam int WW  = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          s_sign, s_stk;
    logic [SW+1:0] s_mant;
    logic [1:0]    s_mode;
    logic [SW:0]   s_out;
    logic          s_incr, s_inx, s_sto;

    logic          w_sign, w_stk;
    logic [WW+1:0] w_mant;
    logic [1:0]    w_mode;
    logic [WW:0]   w_out;
    logic          w_incr, w_inx, w_sto;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    mant_round #(.MANT_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .sign_i(s_sign), .mant_i(s_mant),
        .sticky_i(s_stk), .mode_i(s_mode), .mant_o(s_out),
        .incr_o(s_incr), .inexact_o(s_inx), .sticky_o(s_sto)
    );

    mant_round #(.MANT_W(WW)) dut_w (
        .clk(clk), .rst_n(rst_n), .sign_i(w_sign), .mant_i(w_mant),
        .sticky_i(w_stk), .mode_i(w_mode), .mant_o(w_out),
        .incr_o(w_incr), .inexact_o(w_inx), .sticky_o(w_sto)
    );

    task automatic check(input string tag, input logic [WW:0] act, input logic [WW:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        s_sign = 0; s_stk = 0; s_mant = '1; s_mode = 2'b11;
        w_sign = 0; w_stk = 1; w_mant = '1; w_mode = 2'b11;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset
        check("R1 mant", WW'(s_out), '0);
        check("R1 flags", {s_incr, s_inx, s_sto}, '0);
        check("R1 wide mant", w_out, '0);
        rst_n = 1'b1;

        for (int v = 0; v < 4096; v++) begin
            logic g, r, st, lsb, sg, lost, inc;
            logic [1:0] md;
            logic [SW:0] exp_m;
            md   = v[11:10];
            sg   = v[9];
            st   = v[8];
            s_mode = md; s_sign = sg; s_stk = st; s_mant = v[7:0];
            g = v[1]; r = v[0]; lsb = v[2];
            lost = g | r | st;
            case (md)
                2'b00: inc = g & (r | st | lsb);
                2'b01: inc = 1'b0;
                2'b10: inc = lost & sg;
                default: inc = lost & ~sg;
            endcase
            exp_m = (SW+1)'(v[7:2]) + (SW+1)'(inc);
            @(negedge clk);
            case (md)
                2'b00: check("R5 incr", WW'(s_incr), WW'(inc));
                2'b01: check("R6 incr", WW'(s_incr), WW'(inc));
                2'b10: check("R7 incr", WW'(s_incr), WW'(inc));
                default: check("R8 incr", WW'(s_incr), WW'(inc));
            endcase
            if (!lost) check("R3 exact", WW'({s_incr, s_inx}), '0);
            else       check("R4 inexact", WW'(s_inx), WW'(1));
            if (v[7:2] == 6'h3f && inc) check("R9 carry", WW'(s_out), WW'(7'h40));
            else                        check("R2 mant", WW'(s_out), WW'(exp_m));
            check("R10 sticky", WW'(s_sto), '0);
        end

        // R9: wide all-ones tie with odd LSB, nearest, carries to the top bit
        w_mode = 2'b00; w_sign = 0; w_stk = 0; w_mant = {{WW{1'b1}}, 2'b10};
        @(negedge clk);
        check("R9 wide carry", w_out, {1'b1, {WW{1'b0}}});
        check("R5 wide tie odd", WW'(w_incr), WW'(1));
        // R5: wide exact tie with even LSB stays
        w_mant = {64'h0000_0000_FFFF_FFFE, 2'b10};
        @(negedge clk);
        check("R5 wide tie even", w_out, 65'h0_0000_0000_FFFF_FFFE);
        // R9: carry across a 32-bit boundary, toward plus infinity
        w_mode = 2'b11; w_mant = {64'h0000_0000_FFFF_FFFF, 2'b00}; w_stk = 1;
        @(negedge clk);
        check("R9 wide mid carry", w_out, 65'h0_0000_0001_0000_0000);
        check("R4 wide sticky only", WW'(w_inx), WW'(1));
        check("R10 wide sticky", WW'(w_sto), '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule